// File: doc/BRIEF.md
# Doppler Sweep Phase Generator

This block produces the carrier phase that a downstream mixer uses to wipe off a trial Doppler frequency, bin after bin, across a whole frequency search. Software loads a signed starting phase increment for the lowest search frequency, a signed step between neighbouring frequencies, a bin count and a samples-per-bin count. A single start pulse then runs the complete sweep with no further attention.

Phase is a 32-bit two's-complement fraction of a half turn: 2^31 corresponds to pi, so a frequency f at sample rate fs needs an increment of 2·f/fs·2^31. Within a bin, a 32-bit accumulator starts from zero and adds that bin's increment once per clock, wrapping modulo 2^32. When a bin ends, the accumulator clears and the increment moves on by the step. The block outputs the full phase, a two-bit quadrant, a per-sample valid strobe, the index of the current bin, a busy flag and a one-cycle done pulse.

Top module: `dsw_phase_gen`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy, valid and done are 0 and both the phase and the bin index are 0.
- R2: A start pulse while idle takes a copy of all four settings. In the next cycle valid is 1, the bin index is 0 and the phase is 0.
- R3: Within a bin, the phase of sample k (counting from 0) equals k times that bin's increment, modulo 2^32. Valid is 1 for every sample and there are no idle gaps.
- R4: Each bin lasts exactly samples-per-bin cycles. The phase returns to 0 on the first sample of every bin.
- R5: The increment used in bin b equals start increment + b·step, computed in 32-bit modulo arithmetic, so negative and wrapping values are allowed.
- R6: The bin index output equals the number of the bin whose samples are currently being produced.
- R7: In the cycle after the last sample of the final bin, done is 1 for exactly one cycle and valid and busy are 0. The bin index then holds the final bin number.
- R8: A start with a bin count of 0 or a samples-per-bin count of 0 gives no valid samples and raises done in the next cycle.
- R9: While busy, the start input and any change to the four settings have no effect on the running sweep.
- R10: Asserting reset during a sweep stops it at once. All outputs return to their R1 values, and no done pulse follows.
- R11: The quadrant output equals the top two bits of the phase: 0 covers [0, pi/2), 1 covers [pi/2, pi), 2 covers [-pi, -pi/2) and 3 covers [-pi/2, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; acted on only while idle |
| inc_start_i | input | 32 | Signed phase increment for bin 0 |
| inc_step_i | input | 32 | Signed change of increment from one bin to the next |
| bin_count_i | input | 8 | Number of bins to sweep |
| samp_per_bin_i | input | 16 | Samples per bin |
| phase_o | output | 32 | Current phase, 2^31 equals pi |
| quad_o | output | 2 | Quadrant of the current phase |
| phase_valid_o | output | 1 | Phase and quadrant are a live sample |
| bin_idx_o | output | 8 | Index of the current bin |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse after the final sample |

## Verification
The hardest case to reach from the ports is a bin increment that wraps past the signed limit part way through a sweep, together with a start pulse and changed settings arriving in the middle of a bin. Both must leave the sample sequence untouched. The stimulus reaches the wrap with directed sweeps whose start increment sits just below +pi and whose step is large and positive. Random sweeps pulse start with scrambled settings at a randomly chosen sample, and the bench compares every sample against k·(start + b·step) modulo 2^32.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    localparam int PHASE_W = 32;
    localparam int QUAD_W  = 2;
    typedef logic [PHASE_W-1:0] phase_t;

    function automatic logic [QUAD_W-1:0] quadrant_of(input phase_t ph);
        return ph[PHASE_W-1 -: QUAD_W];
    endfunction
endpackage

// File: rtl/dsw_phase_acc.sv
module dsw_phase_acc
    import dsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr_i,
    input  logic   add_i,
    input  phase_t inc_i,
    output phase_t acc_o
);
    phase_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i)
            acc_d = '0;
        else if (add_i)
            acc_d = acc_q + inc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    // R4: a clear always wins over an add
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_q == '0);
endmodule

// File: rtl/dsw_sweep_ctrl.sv
module dsw_sweep_ctrl
    import dsw_pkg::*;
#(
    parameter int BIN_W  = 8,
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  phase_t            inc_start_i,
    input  phase_t            inc_step_i,
    input  logic [BIN_W-1:0]  bin_count_i,
    input  logic [SAMP_W-1:0] samp_per_bin_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BIN_W-1:0]  bin_o,
    output logic [SAMP_W-1:0] samp_o,
    output phase_t            inc_o,
    output phase_t            step_o,
    output logic              acc_clr_o,
    output logic              acc_add_o
);
    localparam logic [BIN_W-1:0]  BIN_ONE  = BIN_W'(1);
    localparam logic [SAMP_W-1:0] SAMP_ONE = SAMP_W'(1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [BIN_W-1:0]  bin;
        logic [SAMP_W-1:0] samp;
        logic [BIN_W-1:0]  nbins;
        logic [SAMP_W-1:0] nsamp;
        phase_t            inc;
        phase_t            step;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  clr_d, add_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_d     = 1'b0;
        add_d     = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.inc   = inc_start_i;
                st_d.step  = inc_step_i;
                st_d.nbins = bin_count_i;
                st_d.nsamp = samp_per_bin_i;
                st_d.bin   = '0;
                st_d.samp  = '0;
                clr_d      = 1'b1;
                if (bin_count_i == '0 || samp_per_bin_i == '0)
                    st_d.done = 1'b1;
                else
                    st_d.busy = 1'b1;
            end
        end else if (st_q.samp == st_q.nsamp - SAMP_ONE) begin
            st_d.samp = '0;
            st_d.inc  = st_q.inc + st_q.step;
            clr_d     = 1'b1;
            if (st_q.bin == st_q.nbins - BIN_ONE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.bin = st_q.bin + BIN_ONE;
            end
        end else begin
            st_d.samp = st_q.samp + SAMP_ONE;
            add_d     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign bin_o     = st_q.bin;
    assign samp_o    = st_q.samp;
    assign inc_o     = st_q.inc;
    assign step_o    = st_q.step;
    assign acc_clr_o = clr_d;
    assign acc_add_o = add_d;

    // R6: the bin index never reaches the programmed count while busy
    p_bin_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.bin < st_q.nbins);

    // R4: the sample counter stays below the samples-per-bin count
    p_samp_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.samp < st_q.nsamp);

    // R9: settings held for the whole sweep
    p_settings_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && $past(st_q.busy) |-> $stable(st_q.nbins) && $stable(st_q.nsamp) && $stable(st_q.step));
endmodule

// File: rtl/dsw_phase_gen.sv
module dsw_phase_gen
    import dsw_pkg::*;
#(
    parameter int BIN_W  = 8,
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       inc_start_i,
    input  logic [31:0]       inc_step_i,
    input  logic [BIN_W-1:0]  bin_count_i,
    input  logic [SAMP_W-1:0] samp_per_bin_i,
    output logic [31:0]       phase_o,
    output logic [1:0]        quad_o,
    output logic              phase_valid_o,
    output logic [BIN_W-1:0]  bin_idx_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              busy, done, acc_clr, acc_add;
    logic [BIN_W-1:0]  bin;
    logic [SAMP_W-1:0] samp;
    phase_t            inc, step, acc;

    dsw_sweep_ctrl #(.BIN_W(BIN_W), .SAMP_W(SAMP_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .inc_start_i    (inc_start_i),
        .inc_step_i     (inc_step_i),
        .bin_count_i    (bin_count_i),
        .samp_per_bin_i (samp_per_bin_i),
        .busy_o         (busy),
        .done_o         (done),
        .bin_o          (bin),
        .samp_o         (samp),
        .inc_o          (inc),
        .step_o         (step),
        .acc_clr_o      (acc_clr),
        .acc_add_o      (acc_add)
    );

    dsw_phase_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (acc_clr),
        .add_i (acc_add),
        .inc_i (inc),
        .acc_o (acc)
    );

    assign phase_o       = acc;
    assign quad_o        = quadrant_of(acc);
    assign phase_valid_o = busy;
    assign bin_idx_o     = bin;
    assign busy_o        = busy;
    assign done_o        = done;

    // R4: first sample of every bin starts from zero phase
    p_bin_start_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && samp == '0 |-> acc == '0);

    // R3: consecutive samples inside one bin differ by that bin's increment
    p_accumulate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && samp != '0 |-> acc == $past(acc) + $past(inc));

    // R5: moving to a new bin adds the step to the increment
    p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && bin != $past(bin) |-> inc == $past(inc) + step);

    // R7: done is a single pulse with no live sample beside it
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);
endmodule

// File: tb/dsw_phase_gen_test.sv
module dsw_phase_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] inc_start_i = '0;
    logic [31:0] inc_step_i = '0;
    logic [7:0]  bin_count_i = '0;
    logic [15:0] samp_per_bin_i = '0;
    logic [31:0] phase_o;
    logic [1:0]  quad_o;
    logic        phase_valid_o;
    logic [7:0]  bin_idx_o;
    logic        busy_o;
    logic        done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dsw_phase_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .inc_start_i(inc_start_i), .inc_step_i(inc_step_i),
        .bin_count_i(bin_count_i), .samp_per_bin_i(samp_per_bin_i),
        .phase_o(phase_o), .quad_o(quad_o), .phase_valid_o(phase_valid_o),
        .bin_idx_o(bin_idx_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [31:0] exp_phase(logic [31:0] i0, logic [31:0] st, int b, int k);
        logic [31:0] ib;
        ib = i0 + st * 32'(b);
        return ib * 32'(k);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle(string req);
        chk(busy_o == 0 && phase_valid_o == 0 && done_o == 0, req,
            {29'd0, busy_o, phase_valid_o, done_o}, 32'd0);
        chk(phase_o == 0 && bin_idx_o == 0, req, phase_o | 32'(bin_idx_o), 32'd0);
    endtask

    // poke >= 0: at that sample index, pulse start with scrambled settings (R9)
    task automatic run_sweep(logic [31:0] i0, logic [31:0] st, int nb, int ns, int poke);
        int idx = 0;
        logic [31:0] e;
        inc_start_i = i0; inc_step_i = st;
        bin_count_i = 8'(nb); samp_per_bin_i = 16'(ns);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (nb == 0 || ns == 0) begin
            chk(done_o == 1 && phase_valid_o == 0, "R8", {30'd0, done_o, phase_valid_o}, 32'd2);
            @(negedge clk);
            chk(done_o == 0 && busy_o == 0, "R8", {30'd0, done_o, busy_o}, 32'd0);
            return;
        end
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < ns; k++) begin
                e = exp_phase(i0, st, b, k);
                chk(phase_valid_o == 1 && busy_o == 1, "R3", {31'd0, phase_valid_o}, 32'd1);
                chk(phase_o == e, (k == 0) ? "R4" : (b > 0 ? "R5" : "R3"), phase_o, e);
                chk(bin_idx_o == 8'(b), "R6", 32'(bin_idx_o), 32'(b));
                chk(quad_o == e[31:30], "R11", 32'(quad_o), 32'(e[31:30]));
                chk(done_o == 0, "R7", 32'(done_o), 32'd0);
                if (idx == poke) begin
                    start_i = 1'b1;
                    inc_start_i = $urandom; inc_step_i = $urandom;
                    bin_count_i = 8'($urandom); samp_per_bin_i = 16'($urandom);
                end else begin
                    start_i = 1'b0;
                end
                idx++;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(done_o == 1 && phase_valid_o == 0 && busy_o == 0, "R7",
            {29'd0, done_o, phase_valid_o, busy_o}, 32'd4);
        chk(bin_idx_o == 8'(nb - 1), "R7", 32'(bin_idx_o), 32'(nb - 1));
        @(negedge clk);
        chk(done_o == 0, "R7", 32'(done_o), 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // R2/R3/R5: positive start, negative step
        run_sweep(32'h0100_0000, 32'hFFF0_0000, 3, 5, -1);
        // R5: increment wraps past +pi partway through the sweep
        run_sweep(32'h7FFF_F000, 32'h0000_0800, 4, 6, -1);
        // R11: large increment hitting every quadrant
        run_sweep(32'h5000_0000, 32'h4000_0001, 2, 9, -1);
        // R4: one sample per bin
        run_sweep(32'h1234_5678, 32'h1111_1111, 5, 1, -1);
        // R8: zero bins and zero samples
        run_sweep(32'h1000_0000, 32'h1, 0, 4, -1);
        run_sweep(32'h1000_0000, 32'h1, 3, 0, -1);
        // R9: restart attempt during the sweep
        run_sweep(32'hC000_0000, 32'h0800_0000, 3, 4, 5);

        for (int i = 0; i < 40; i++) begin
            int nb = 1 + int'($urandom_range(0, 5));
            int ns = 1 + int'($urandom_range(0, 9));
            int pk = int'($urandom_range(0, 60)) - 10;
            run_sweep($urandom, $urandom, nb, ns, pk);
            repeat (int'($urandom_range(0, 2))) @(negedge clk);
        end

        // R10: reset in mid-sweep
        inc_start_i = 32'h0400_0000; inc_step_i = 32'h0010_0000;
        bin_count_i = 8'd6; samp_per_bin_i = 16'd8;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        chk(busy_o == 1 && bin_idx_o == 8'd1, "R10", 32'(bin_idx_o), 32'd1);
        rst_n = 1'b0;
        #1;
        chk_idle("R10");
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            chk_idle("R10");
        end
        finish_run();
    end
endmodule